// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the bus-facing register file of a block-cipher accelerator. A host on a 32-bit, word-addressed slave bus loads a user key and one 128-bit input block, then starts an encrypt or a decrypt pass by writing a control word. The block presents the key, the key-valid flag, the input block and the start levels to a separate cipher engine. When the engine reports completion, the block captures the 128-bit result, drops the start bit and can raise an interrupt.

The key is loaded once and expanded by the engine. To load a new key, the host first clears the key-valid bit, which also aborts any pass in flight. While the engine is still expanding a key, `waitReq` is high and key-window writes are refused. Every output, including `rdata` and `waitReq`, comes from a flop.

Address map, by 5-bit word offset:
- 0 to 7: key words. Offset i drives `keyOut[32i+31:32i]`.
- 8 to 11: input words. Offset 8+i drives `dataOut[32i+31:32i]`.
- 12 to 15: result words. Offset 12+i returns result bits [32i+31:32i].
- 31: control word.
- All other offsets are reserved.

Top module: `blkcipher_csr`

## Requirements
- R1: A write to offset i below KEY_BITS/32 stores `wdata` in `keyOut[32i+31:32i]`. A write to offset 8+i (i = 0..3) stores `wdata` in `dataOut[32i+31:32i]`. Both are visible on the engine side from the cycle after the write.
- R2: `rdata` shows the addressed word in the cycle after a read and is zero in every other cycle. Reads of the key window, the input window and reserved offsets 16..30 return zero.
- R3: The control word reads back as key-valid in bit 7, interrupt-enable in bit 6, decrypt in bit 1 and encrypt in bit 0. All other bits read as zero.
- R4: While `rst` is high at a clock edge, the control word clears to zero. From the next cycle `irq`, `waitReq`, `keyValid`, `startEnc` and `startDec` are low.
- R5: A control write with bit 0 set and bit 1 clear raises `startEnc` in the next cycle. Bit 1 with bit 0 clear raises `startDec` in the same way. A control write with both bits set leaves encrypt and decrypt unchanged but still updates bits 7 and 6.
- R6: When `done` is high while a pass is running, the block clears the encrypt and decrypt bits at that edge. It also captures `resultIn`, and the captured value stays readable until the next completion.
- R7: A completion raises `irq` when interrupt-enable is set. With interrupt-enable clear, `irq` stays low.
- R8: `irq` drops after a read of any of offsets 12..15, or after a control write that clears bit 6. If a completion and a result read share a cycle, `irq` stays high and the read returns the previous result.
- R9: `waitReq` is high in the cycle after key-valid is set, and stays high until the engine raises `keyReady`. A key-window write made while `waitReq` is high is discarded.
- R10: A control write that clears bit 7 drops `keyValid`, `startEnc` and `startDec` in the next cycle. No completion or interrupt follows.
- R11: Writes to the result window and to reserved offsets change no readable or engine-side state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Word offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd` |
| waitReq | output | 1 | Key window busy (key expansion running) |
| irq | output | 1 | Completion interrupt |
| keyOut | output | KEY_BITS | Key to engine |
| keyValid | output | 1 | Key-valid level to engine |
| dataOut | output | 128 | Input block to engine |
| startEnc | output | 1 | Encrypt request level |
| startDec | output | 1 | Decrypt request level |
| keyReady | input | 1 | Engine has finished key expansion |
| done | input | 1 | One-cycle completion pulse from engine |
| resultIn | input | 128 | Engine result, valid with `done` |

## Verification
An engine completion can land in the same cycle as a host read of the result window. One event sets the interrupt and the other clears it, and at the same edge the result register is replaced. The bench places the read exactly on the edge where its engine model pulses `done`. It expects `irq` to stay high and the returned word to be the old result. A later read must then return the new result and clear `irq`.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int ADDR_W    = 5;
  localparam int WORD_W    = 32;
  localparam int BLK_W     = 128;
  localparam int BLK_WORDS = BLK_W / WORD_W;

  localparam logic [ADDR_W-1:0] DATA_BASE = 5'd8;
  localparam logic [ADDR_W-1:0] RES_BASE  = 5'd12;
  localparam logic [ADDR_W-1:0] RES_END   = 5'd16;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'd31;

  // control field positions in the readable word
  localparam int CB_ENC = 0;
  localparam int CB_DEC = 1;
  localparam int CB_IE  = 6;
  localparam int CB_KV  = 7;

  typedef enum logic [1:0] {
    RS_ZERO   = 2'd0,
    RS_RESULT = 2'd1,
    RS_CTRL   = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic       keyWe;
    logic       dataWe;
    logic       resCap;
    logic       rdEn;
    rdSrc_e     rdSrc;
    logic [2:0] word;
  } dpStrobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int KEY_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [3:0]        ctrlIn,   // {kv, ie, dec, enc} from the write word
  input  logic              keyReady,
  input  logic              done,
  output dpStrobe_t         strb,
  output logic [WORD_W-1:0] ctrlWord,
  output logic              keyValid,
  output logic              startEnc,
  output logic              startDec,
  output logic              irq,
  output logic              waitReq
);
  localparam logic [ADDR_W-1:0] KEY_LIM = ADDR_W'(KEY_WORDS);

  logic kvQ, ieQ, encQ, decQ, irqQ, waitQ;
  logic inKey, inData, inRes, isCtrl, ctrlWr;
  logic busy, finish, resRead;
  logic kvN, ieN, encN, decN, irqN, waitN;

  always_comb begin
    inKey   = addr < KEY_LIM;
    inData  = (addr >= DATA_BASE) && (addr < RES_BASE);
    inRes   = (addr >= RES_BASE) && (addr < RES_END);
    isCtrl  = addr == CTRL_ADDR;
    ctrlWr  = wr && isCtrl;
    busy    = encQ || decQ;
    finish  = done && busy;
    resRead = rd && inRes;
  end

  // next-state of the control word
  always_comb begin
    kvN  = ctrlWr ? ctrlIn[3] : kvQ;
    ieN  = ctrlWr ? ctrlIn[2] : ieQ;
    encN = finish ? 1'b0 : encQ;
    decN = finish ? 1'b0 : decQ;
    if (ctrlWr && !(ctrlIn[1] && ctrlIn[0])) begin
      encN = ctrlIn[0];
      decN = ctrlIn[1];
    end
    if (!kvN) begin
      encN = 1'b0;
      decN = 1'b0;
    end
    irqN  = ieN && (finish || (irqQ && !resRead));
    waitN = kvN && !keyReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kvQ   <= 1'b0;
      ieQ   <= 1'b0;
      encQ  <= 1'b0;
      decQ  <= 1'b0;
      irqQ  <= 1'b0;
      waitQ <= 1'b0;
    end else begin
      kvQ   <= kvN;
      ieQ   <= ieN;
      encQ  <= encN;
      decQ  <= decN;
      irqQ  <= irqN;
      waitQ <= waitN;
    end
  end

  always_comb begin
    strb.keyWe  = wr && inKey && !waitQ;
    strb.dataWe = wr && inData;
    strb.resCap = finish;
    strb.rdEn   = rd;
    if (inRes)       strb.rdSrc = RS_RESULT;
    else if (isCtrl) strb.rdSrc = RS_CTRL;
    else             strb.rdSrc = RS_ZERO;
    strb.word   = addr[2:0];
  end

  always_comb begin
    ctrlWord         = '0;
    ctrlWord[CB_KV]  = kvQ;
    ctrlWord[CB_IE]  = ieQ;
    ctrlWord[CB_DEC] = decQ;
    ctrlWord[CB_ENC] = encQ;
  end

  assign keyValid = kvQ;
  assign startEnc = encQ;
  assign startDec = decQ;
  assign irq      = irqQ;
  assign waitReq  = waitQ;
endmodule

// File: rtl/csr_dpath.sv
module csr_dpath
  import csr_pkg::*;
#(
  parameter int KEY_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  dpStrobe_t                   strb,
  input  logic [WORD_W-1:0]           wdata,
  input  logic [WORD_W-1:0]           ctrlWord,
  input  logic [BLK_W-1:0]            resultIn,
  output logic [KEY_WORDS*WORD_W-1:0] keyOut,
  output logic [BLK_W-1:0]            dataOut,
  output logic [WORD_W-1:0]           rdata
);
  logic [WORD_W-1:0] resW [BLK_WORDS];

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) keyOut[i*WORD_W +: WORD_W] <= '0;
      else if (strb.keyWe && strb.word == 3'(i))
        keyOut[i*WORD_W +: WORD_W] <= wdata;
    end
  end

  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) begin
        dataOut[j*WORD_W +: WORD_W] <= '0;
        resW[j] <= '0;
      end else begin
        if (strb.dataWe && strb.word == 3'(j))
          dataOut[j*WORD_W +: WORD_W] <= wdata;
        if (strb.resCap)
          resW[j] <= resultIn[j*WORD_W +: WORD_W];
      end
    end
  end

  logic [WORD_W-1:0] rdMux;
  always_comb begin
    unique case (strb.rdSrc)
      RS_RESULT: rdMux = resW[strb.word[1:0]];
      RS_CTRL:   rdMux = ctrlWord;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (strb.rdEn) rdata <= rdMux;
    else                rdata <= '0;
  end
endmodule

// File: rtl/blkcipher_csr.sv
module blkcipher_csr
  import csr_pkg::*;
#(
  parameter int KEY_BITS = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4:0]          addr,
  input  logic                rd,
  input  logic                wr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                waitReq,
  output logic                irq,
  output logic [KEY_BITS-1:0] keyOut,
  output logic                keyValid,
  output logic [127:0]        dataOut,
  output logic                startEnc,
  output logic                startDec,
  input  logic                keyReady,
  input  logic                done,
  input  logic [127:0]        resultIn
);
  localparam int KEY_WORDS = KEY_BITS / WORD_W;

  dpStrobe_t         strb;
  logic [WORD_W-1:0] ctrlWord;
  logic [3:0]        ctrlIn;

  assign ctrlIn = {wdata[CB_KV], wdata[CB_IE], wdata[CB_DEC], wdata[CB_ENC]};

  csr_ctrl #(.KEY_WORDS(KEY_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .ctrlIn(ctrlIn),
    .keyReady(keyReady), .done(done), .strb(strb), .ctrlWord(ctrlWord),
    .keyValid(keyValid), .startEnc(startEnc), .startDec(startDec),
    .irq(irq), .waitReq(waitReq)
  );

  csr_dpath #(.KEY_WORDS(KEY_WORDS)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .wdata(wdata), .ctrlWord(ctrlWord),
    .resultIn(resultIn), .keyOut(keyOut), .dataOut(dataOut), .rdata(rdata)
  );
endmodule

// File: rtl/blkcipher_csr_chk.sv
module blkcipher_csr_chk #(
  parameter int KEY_BITS = 256
) (
  input logic                clk,
  input logic                rst,
  input logic [4:0]          addr,
  input logic                rd,
  input logic                wr,
  input logic [31:0]         rdata,
  input logic                waitReq,
  input logic                irq,
  input logic                irqEna,
  input logic [KEY_BITS-1:0] keyOut,
  input logic                keyValid,
  input logic                startEnc,
  input logic                startDec,
  input logic                done
);
  localparam logic [4:0] KEY_LIM = 5'(KEY_BITS / 32);

  // R5
  enc_dec_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(startEnc && startDec));

  // R10
  abort_kv_chk: assert property (@(posedge clk) disable iff (rst)
    !keyValid |-> (!startEnc && !startDec));

  // R9
  key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && waitReq && addr < KEY_LIM) |=> $stable(keyOut));

  // R2
  rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr >= 5'd16 && addr <= 5'd30) |=> (rdata == 32'd0));

  // R7
  irq_needs_ena_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> irqEna);

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (startEnc || startDec) && !wr) |=> (!startEnc && !startDec));

  // R4
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq && !keyValid && !waitReq && !startEnc && !startDec));

  // R8
  irq_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && rd && addr >= 5'd12 && addr <= 5'd15 && !done) |=> !irq);
endmodule

bind blkcipher_csr blkcipher_csr_chk #(.KEY_BITS(KEY_BITS)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .rdata(rdata),
  .waitReq(waitReq), .irq(irq), .irqEna(ctrlWord[6]), .keyOut(keyOut),
  .keyValid(keyValid), .startEnc(startEnc), .startDec(startDec), .done(done)
);

// File: tb/blkcipher_csr_tb.sv
module blkcipher_csr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_BITS   = 256;
  localparam int LAT        = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [4:0]          addr = '0;
  logic                rd = 1'b0, wr = 1'b0;
  logic [31:0]         wdata = '0;
  logic [31:0]         rdata;
  logic                waitReq, irq, keyValid, startEnc, startDec;
  logic [KEY_BITS-1:0] keyOut;
  logic [127:0]        dataOut;
  logic                keyReady = 1'b0, done = 1'b0;
  logic [127:0]        resultIn = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkcipher_csr #(.KEY_BITS(KEY_BITS)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .waitReq(waitReq), .irq(irq), .keyOut(keyOut),
    .keyValid(keyValid), .dataOut(dataOut), .startEnc(startEnc),
    .startDec(startDec), .keyReady(keyReady), .done(done), .resultIn(resultIn)
  );

  // behavioural engine: expands in 4 cycles, completes LAT cycles after start
  int krCnt = 0;
  int opCnt = 0;
  always @(posedge clk) begin
    if (!keyValid) begin
      krCnt    <= 0;
      keyReady <= 1'b0;
      opCnt    <= 0;
      done     <= 1'b0;
    end else begin
      if (!keyReady) begin
        krCnt <= krCnt + 1;
        if (krCnt == 3) keyReady <= 1'b1;
      end
      done <= 1'b0;
      if ((startEnc || startDec) && keyReady && !done) begin
        if (opCnt == LAT-1) begin
          opCnt    <= 0;
          done     <= 1'b1;
          resultIn <= startEnc ? (dataOut ^ keyOut[127:0]) : (dataOut ^ ~keyOut[127:0]);
        end else begin
          opCnt <= opCnt + 1;
        end
      end
    end
  end

  // scoreboard for read data
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdSeen <= rd;

  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(rdata, e, t);
    end
  end

  // driver tasks: called at a falling edge, return at the next falling edge
  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 30; k++) begin
      if (!startEnc && !startDec) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
    finish_run();
  end

  logic [31:0]  kw [8];
  logic [127:0] blkA, blkB, blkC, keyLo, encA, decB, encA2, encC;

  initial begin
    for (int i = 0; i < 8; i++) kw[i] = 32'h1357_0000 + 32'(i * 32'h0101);
    blkA = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    blkB = 128'hcafef00d_12345678_9abcdef0_55aa55aa;
    blkC = 128'h01234567_89abcdef_fedcba98_76543210;
    keyLo = {kw[3], kw[2], kw[1], kw[0]};
    encA = blkA ^ keyLo;
    decB = blkB ^ ~keyLo;
    encC = blkC ^ keyLo;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 reset state
    check({27'd0, irq, waitReq, keyValid, startEnc, startDec}, 32'd0, "R4 outputs after reset");
    busRd(5'd31, 32'd0, "R4 control word after reset");

    // R1 key and input windows
    for (int i = 0; i < 8; i++) busWr(5'(i), kw[i]);
    busWr(5'd8,  blkA[31:0]);
    busWr(5'd9,  blkA[63:32]);
    busWr(5'd10, blkA[95:64]);
    busWr(5'd11, blkA[127:96]);
    check(keyOut[31:0], kw[0], "R1 key word 0");
    check(keyOut[255:224], kw[7], "R1 key word 7");
    check(dataOut[63:32], blkA[63:32], "R1 input word 1");
    check(dataOut[127:96], blkA[127:96], "R1 input word 3");

    // R2 write-only and reserved reads
    busRd(5'd2,  32'd0, "R2 key window reads zero");
    busRd(5'd9,  32'd0, "R2 input window reads zero");
    busRd(5'd20, 32'd0, "R2 reserved reads zero");
    @(negedge clk);
    check(rdata, 32'd0, "R2 rdata zero when idle");

    // R9 key expansion busy
    busWr(5'd31, 32'h80);
    check({31'd0, waitReq}, 32'd1, "R9 waitReq during expansion");
    busWr(5'd0, 32'hdead_beef);
    check(keyOut[31:0], kw[0], "R9 key write refused while busy");
    for (int k = 0; k < 20; k++) begin
      if (!waitReq) break;
      @(negedge clk);
    end
    check({31'd0, waitReq}, 32'd0, "R9 waitReq released");

    // R5 both start bits: no-op on them, ie still updated
    busWr(5'd31, 32'hC3);
    check({30'd0, startEnc, startDec}, 32'd0, "R5 both bits ignored");
    busRd(5'd31, 32'hC0, "R5 R3 control readback");

    // R5 R6 R7 encrypt with interrupt
    busWr(5'd31, 32'hC1);
    check({31'd0, startEnc}, 32'd1, "R5 startEnc raised");
    waitIdle();
    check({31'd0, irq}, 32'd1, "R7 irq on completion");
    busRd(5'd31, 32'hC0, "R6 R3 enc bit cleared");
    busRd(5'd12, encA[31:0], "R6 result word 0");
    check({31'd0, irq}, 32'd0, "R8 irq cleared by result read");
    busRd(5'd13, encA[63:32], "R6 result word 1");
    busRd(5'd14, encA[95:64], "R6 result word 2");
    busRd(5'd15, encA[127:96], "R6 result word 3");

    // R11 ignored writes
    busWr(5'd13, 32'h1111_2222);
    busRd(5'd13, encA[63:32], "R11 result window write ignored");
    busWr(5'd25, 32'h3333_4444);
    busRd(5'd25, 32'd0, "R11 reserved write ignored");
    check(dataOut, blkA, "R11 input unchanged");

    // R7 decrypt without interrupt
    busWr(5'd8,  blkB[31:0]);
    busWr(5'd9,  blkB[63:32]);
    busWr(5'd10, blkB[95:64]);
    busWr(5'd11, blkB[127:96]);
    busWr(5'd31, 32'h82);
    check({31'd0, startDec}, 32'd1, "R5 startDec raised");
    waitIdle();
    repeat (2) @(negedge clk);
    check({31'd0, irq}, 32'd0, "R7 no irq when disabled");
    busRd(5'd12, decB[31:0], "R6 decrypt result word 0");
    busRd(5'd15, decB[127:96], "R6 decrypt result word 3");

    // R8 clearing interrupt-enable
    busWr(5'd8, blkA[31:0]);
    busWr(5'd9, blkA[63:32]);
    busWr(5'd10, blkA[95:64]);
    busWr(5'd11, blkA[127:96]);
    busWr(5'd31, 32'hC1);
    waitIdle();
    check({31'd0, irq}, 32'd1, "R8 irq set before enable clear");
    busWr(5'd31, 32'h80);
    check({31'd0, irq}, 32'd0, "R8 irq cleared by enable clear");

    // R8 completion and result read in the same cycle
    busWr(5'd31, 32'hC1);
    waitIdle();
    check({31'd0, irq}, 32'd1, "R8 irq pending");
    encA2 = encA;
    busWr(5'd8,  blkC[31:0]);
    busWr(5'd9,  blkC[63:32]);
    busWr(5'd10, blkC[95:64]);
    busWr(5'd11, blkC[127:96]);
    busWr(5'd31, 32'hC1);
    repeat (3) @(negedge clk);
    check({31'd0, done}, 32'd1, "R8 engine done aligned with read");
    busRd(5'd12, encA2[31:0], "R8 collision read returns old result");
    check({31'd0, irq}, 32'd1, "R8 irq kept on collision");
    busRd(5'd12, encC[31:0], "R8 new result after collision");
    check({31'd0, irq}, 32'd0, "R8 irq cleared after second read");

    // R10 abort
    busWr(5'd31, 32'hC1);
    busWr(5'd31, 32'h40);
    check({29'd0, keyValid, startEnc, startDec}, 32'd0, "R10 abort clears levels");
    repeat (8) @(negedge clk);
    check({30'd0, irq, waitReq}, 32'd0, "R10 no irq after abort");
    busRd(5'd31, 32'h40, "R10 R3 control after abort");

    // R4 reset while active
    busWr(5'd31, 32'hC0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    busRd(5'd31, 32'd0, "R4 control cleared by reset");
    check({30'd0, keyValid, waitReq}, 32'd0, "R4 key invalid after reset");

    @(negedge clk);
    finish_run();
  end
endmodule